// File: doc/BRIEF.md
# Thermal Skew Compensation Controller

This block holds clock-distribution paths at a steady delay while the die temperature moves. Before a run, a schedule of temperature samples is written into a small internal table. Each sample carries the number of clock cycles for which it stays in force. A second table is also written: a temperature map that gives, for every coarse temperature bin, the expected delay of each distribution path. Once started, the controller walks the schedule. A newly loaded temperature only becomes visible to the decision logic after a fixed number of cycles, which stands in for the time needed to compute delays. After that wait, the controller looks up each path in turn and compares the mapped delay against a threshold.

For each path the result is one of three outcomes. No correction returns the path to nominal. A small excess is absorbed by a supply-voltage trim code. A larger excess is absorbed by switching whole flip-flop delay stages into the path, and the stage count is also given as a one-hot tap select for a demultiplexer-style path selector. When even the largest stage count cannot cover the excess, the path is clamped at that maximum and flagged. A one-cycle pulse marks the end of each evaluation pass.

Top module: `tsc_ctrl`

## Requirements
- R1: While reset is low and right after it, every voltage code and stage count is 0, every tap select has only bit 0 set, the out-of-range flags are 0, and `done_o` and `busy_o` are 0.
- R2: Writes through the schedule and map write ports set the entry used by later runs. Rewriting an entry between runs changes the result produced for it.
- R3: A start seen while idle loads schedule entry 0. The first `done_o` pulse appears exactly LAT + NPATH + 1 clock edges after the edge that sampled `start_i` (8 edges with the defaults).
- R4: The temperature bin is the upper 3 bits of the 7-bit sample temperature. Path p uses the map entry written for that bin and path index p.
- R5: A path whose mapped delay is less than or equal to `thresh_i` gets voltage code 0 and stage count 0.
- R6: A path with excess E = delay - threshold, where 1 <= E <= FINE_WIN (8), gets voltage code E and stage count 0.
- R7: A path with excess E > FINE_WIN gets voltage code 0 and stage count ceil(E / 16), provided that count is at most 7.
- R8: When ceil(E / 16) exceeds 7, the stage count is 7 and that path's out-of-range flag is 1. Otherwise the flag is 0.
- R9: Each path's 8-bit tap select (bits p*8 .. p*8+7 of `tap_sel_o`) has exactly the bit at the stage count set.
- R10: `done_o` is a single-cycle pulse, issued once per schedule entry and only while `busy_o` is high. Consecutive pulses are max(D, LAT + NPATH) + 2 cycles apart, where D is the 16-bit dwell count of the earlier entry.
- R11: After the entry at index `sched_last_i` completes, `busy_o` drops and all path outputs hold their last values.
- R12: A start pulse while `busy_o` is high has no effect: the run still produces exactly `sched_last_i` + 1 done pulses, with unchanged timing and values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin walking the schedule from entry 0 |
| thresh_i | input | 8 | Delay threshold for correction |
| sched_last_i | input | 3 | Index of the final schedule entry |
| sched_we_i | input | 1 | Schedule table write strobe |
| sched_addr_i | input | 3 | Schedule entry to write |
| sched_temp_i | input | 7 | Temperature value of the entry |
| sched_dwell_i | input | 16 | Dwell count of the entry, in cycles |
| map_we_i | input | 1 | Temperature map write strobe |
| map_bin_i | input | 3 | Temperature bin to write |
| map_path_i | input | 2 | Path index to write |
| map_delay_i | input | 8 | Delay value for that bin and path |
| vcode_o | output | 12 | Supply trim code, 4 bits per path |
| stages_o | output | 9 | Inserted stage count, 3 bits per path |
| tap_sel_o | output | 24 | One-hot stage tap select, 8 bits per path |
| oor_o | output | 3 | Per-path out-of-range flag |
| done_o | output | 1 | One-cycle pulse after all paths of a sample are evaluated |
| busy_o | output | 1 | Schedule walk in progress |

## Verification
The interesting coincidence is a done pulse landing in the same cycle in which the current sample's dwell count has already run out. In that case the controller must load the next entry on the very next edge instead of holding. Schedule entries with dwell 0 and 1 provoke this case, alongside entries whose dwell far exceeds the evaluation time. The scoreboard judges the result by the exact spacing between done pulses and by the per-path outputs attached to each pulse. A start pulse injected mid-run is judged the same way, together with a count of the done pulses in that run.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT,
    SQ_EVAL,
    SQ_HOLD
  } seq_state_e;
endpackage

// File: rtl/tsc_sched.sv
module tsc_sched
  import tsc_pkg::*;
#(
  parameter int NSAMP   = 8,
  parameter int TEMP_W  = 7,
  parameter int DWELL_W = 16,
  parameter int NPATH   = 3,
  parameter int LAT     = 4,
  localparam int IDX_W  = $clog2(NSAMP),
  localparam int PW     = $clog2(NPATH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   last_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [TEMP_W-1:0]  wr_temp_i,
  input  logic [DWELL_W-1:0] wr_dwell_i,
  output logic               eval_o,
  output logic [PW-1:0]      path_o,
  output logic [TEMP_W-1:0]  temp_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam int LAT_W = $clog2(LAT + 1);

  logic [TEMP_W-1:0]  temp_mem  [NSAMP];
  logic [DWELL_W-1:0] dwell_mem [NSAMP];

  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DWELL_W-1:0] dwell_q, dwell_d;
  logic [LAT_W-1:0]   lat_q, lat_d;
  logic [PW-1:0]      path_q, path_d;
  logic [TEMP_W-1:0]  pend_q, pend_d;
  logic [TEMP_W-1:0]  seen_q, seen_d;
  logic               done_q, done_d;

  // schedule table, written between runs
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      temp_mem[wr_addr_i]  <= wr_temp_i;
      dwell_mem[wr_addr_i] <= wr_dwell_i;
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dwell_d = (dwell_q != '0) ? dwell_q - DWELL_W'(1) : dwell_q;
    lat_d   = lat_q;
    path_d  = path_q;
    pend_d  = pend_q;
    seen_d  = seen_q;
    done_d  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          idx_d   = '0;
          state_d = SQ_LOAD;
        end
      end
      SQ_LOAD: begin
        pend_d  = temp_mem[idx_q];
        dwell_d = dwell_mem[idx_q];
        lat_d   = '0;
        state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        // the new temperature becomes visible only after LAT cycles
        if (lat_q == LAT_W'(LAT - 1)) begin
          seen_d  = pend_q;
          path_d  = '0;
          state_d = SQ_EVAL;
        end else begin
          lat_d = lat_q + LAT_W'(1);
        end
      end
      SQ_EVAL: begin
        if (path_q == PW'(NPATH - 1)) begin
          done_d  = 1'b1;
          state_d = SQ_HOLD;
        end else begin
          path_d = path_q + PW'(1);
        end
      end
      SQ_HOLD: begin
        if (dwell_q == '0) begin
          if (idx_q == last_i) begin
            state_d = SQ_IDLE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = SQ_LOAD;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      dwell_q <= '0;
      lat_q   <= '0;
      path_q  <= '0;
      pend_q  <= '0;
      seen_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dwell_q <= dwell_d;
      lat_q   <= lat_d;
      path_q  <= path_d;
      pend_q  <= pend_d;
      seen_q  <= seen_d;
      done_q  <= done_d;
    end
  end

  assign eval_o = (state_q == SQ_EVAL);
  assign path_o = path_q;
  assign temp_o = seen_q;
  assign done_o = done_q;
  assign busy_o = (state_q != SQ_IDLE);
endmodule

// File: rtl/tsc_map.sv
module tsc_map #(
  parameter int NPATH   = 3,
  parameter int TBIN_W  = 3,
  parameter int DELAY_W = 8,
  localparam int PW     = $clog2(NPATH),
  localparam int NBIN   = 2 ** TBIN_W
) (
  input  logic               clk,
  input  logic               wr_en_i,
  input  logic [TBIN_W-1:0]  wr_bin_i,
  input  logic [PW-1:0]      wr_path_i,
  input  logic [DELAY_W-1:0] wr_delay_i,
  input  logic [TBIN_W-1:0]  rd_bin_i,
  input  logic [PW-1:0]      rd_path_i,
  output logic [DELAY_W-1:0] rd_delay_o
);
  logic [NPATH-1:0][DELAY_W-1:0] rd_word;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic [DELAY_W-1:0] mem [NBIN];
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_path_i == PW'(p))) begin
        mem[wr_bin_i] <= wr_delay_i;
      end
    end
    assign rd_word[p] = mem[rd_bin_i];
  end

  always_comb begin
    rd_delay_o = '0;
    for (int p = 0; p < NPATH; p++) begin
      if (rd_path_i == PW'(p)) begin
        rd_delay_o = rd_word[p];
      end
    end
  end
endmodule

// File: rtl/tsc_decide.sv
module tsc_decide #(
  parameter int DELAY_W  = 8,
  parameter int VCODE_W  = 4,
  parameter int STAGE_W  = 3,
  parameter int FINE_WIN = 8,
  parameter int UNIT_SH  = 4
) (
  input  logic [DELAY_W-1:0] delay_i,
  input  logic [DELAY_W-1:0] thresh_i,
  output logic [VCODE_W-1:0] vcode_o,
  output logic [STAGE_W-1:0] stages_o,
  output logic               oor_o
);
  localparam int MAXST = 2 ** STAGE_W - 1;
  localparam int ROUND = 2 ** UNIT_SH - 1;

  logic [DELAY_W-1:0] excess;
  logic [DELAY_W:0]   need;

  always_comb begin
    excess   = (delay_i > thresh_i) ? delay_i - thresh_i : '0;
    need     = ({1'b0, excess} + (DELAY_W + 1)'(ROUND)) >> UNIT_SH;
    vcode_o  = '0;
    stages_o = '0;
    oor_o    = 1'b0;
    if (excess != '0) begin
      if (excess <= DELAY_W'(FINE_WIN)) begin
        vcode_o = excess[VCODE_W-1:0];
      end else if (need > (DELAY_W + 1)'(MAXST)) begin
        stages_o = STAGE_W'(MAXST);
        oor_o    = 1'b1;
      end else begin
        stages_o = need[STAGE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl #(
  parameter int NPATH    = 3,
  parameter int NSAMP    = 8,
  parameter int TEMP_W   = 7,
  parameter int TBIN_W   = 3,
  parameter int DWELL_W  = 16,
  parameter int DELAY_W  = 8,
  parameter int VCODE_W  = 4,
  parameter int STAGE_W  = 3,
  parameter int FINE_WIN = 8,
  parameter int UNIT_SH  = 4,
  parameter int LAT      = 4,
  localparam int IDX_W   = $clog2(NSAMP),
  localparam int PW      = $clog2(NPATH),
  localparam int NTAP    = 2 ** STAGE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [DELAY_W-1:0]         thresh_i,
  input  logic [IDX_W-1:0]           sched_last_i,
  input  logic                       sched_we_i,
  input  logic [IDX_W-1:0]           sched_addr_i,
  input  logic [TEMP_W-1:0]          sched_temp_i,
  input  logic [DWELL_W-1:0]         sched_dwell_i,
  input  logic                       map_we_i,
  input  logic [TBIN_W-1:0]          map_bin_i,
  input  logic [PW-1:0]              map_path_i,
  input  logic [DELAY_W-1:0]         map_delay_i,
  output logic [NPATH*VCODE_W-1:0]   vcode_o,
  output logic [NPATH*STAGE_W-1:0]   stages_o,
  output logic [NPATH*NTAP-1:0]      tap_sel_o,
  output logic [NPATH-1:0]           oor_o,
  output logic                       done_o,
  output logic                       busy_o
);
  logic               eval;
  logic [PW-1:0]      eval_path;
  logic [TEMP_W-1:0]  seen_temp;
  logic [DELAY_W-1:0] map_delay;
  logic [VCODE_W-1:0] dec_vcode;
  logic [STAGE_W-1:0] dec_stages;
  logic               dec_oor;

  tsc_sched #(
    .NSAMP(NSAMP), .TEMP_W(TEMP_W), .DWELL_W(DWELL_W),
    .NPATH(NPATH), .LAT(LAT)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .last_i     (sched_last_i),
    .wr_en_i    (sched_we_i),
    .wr_addr_i  (sched_addr_i),
    .wr_temp_i  (sched_temp_i),
    .wr_dwell_i (sched_dwell_i),
    .eval_o     (eval),
    .path_o     (eval_path),
    .temp_o     (seen_temp),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  tsc_map #(
    .NPATH(NPATH), .TBIN_W(TBIN_W), .DELAY_W(DELAY_W)
  ) u_map (
    .clk        (clk),
    .wr_en_i    (map_we_i),
    .wr_bin_i   (map_bin_i),
    .wr_path_i  (map_path_i),
    .wr_delay_i (map_delay_i),
    .rd_bin_i   (seen_temp[TEMP_W-1 -: TBIN_W]),
    .rd_path_i  (eval_path),
    .rd_delay_o (map_delay)
  );

  tsc_decide #(
    .DELAY_W(DELAY_W), .VCODE_W(VCODE_W), .STAGE_W(STAGE_W),
    .FINE_WIN(FINE_WIN), .UNIT_SH(UNIT_SH)
  ) u_decide (
    .delay_i  (map_delay),
    .thresh_i (thresh_i),
    .vcode_o  (dec_vcode),
    .stages_o (dec_stages),
    .oor_o    (dec_oor)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic               upd;
    logic [VCODE_W-1:0] vc_q, vc_d;
    logic [STAGE_W-1:0] st_q, st_d;
    logic               oor_q, oor_d;
    logic [NTAP-1:0]    tap;

    assign upd = eval && (eval_path == PW'(p));

    always_comb begin
      vc_d  = vc_q;
      st_d  = st_q;
      oor_d = oor_q;
      if (upd) begin
        vc_d  = dec_vcode;
        st_d  = dec_stages;
        oor_d = dec_oor;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vc_q  <= '0;
        st_q  <= '0;
        oor_q <= 1'b0;
      end else begin
        vc_q  <= vc_d;
        st_q  <= st_d;
        oor_q <= oor_d;
      end
    end

    // demultiplexer select for the stage tap
    always_comb begin
      tap       = '0;
      tap[st_q] = 1'b1;
    end

    assign vcode_o[p*VCODE_W +: VCODE_W]  = vc_q;
    assign stages_o[p*STAGE_W +: STAGE_W] = st_q;
    assign tap_sel_o[p*NTAP +: NTAP]      = tap;
    assign oor_o[p]                       = oor_q;
  end
endmodule

// File: rtl/tsc_ctrl_chk.sv
module tsc_ctrl_chk #(
  parameter int NPATH   = 3,
  parameter int VCODE_W = 4,
  parameter int STAGE_W = 3,
  localparam int NTAP   = 2 ** STAGE_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPATH*VCODE_W-1:0] vcode_o,
  input logic [NPATH*STAGE_W-1:0] stages_o,
  input logic [NPATH*NTAP-1:0]    tap_sel_o,
  input logic [NPATH-1:0]         oor_o,
  input logic                     done_o,
  input logic                     busy_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_nominal: assert (vcode_o == '0 && stages_o == '0 &&
                                  oor_o == '0 && !done_o && !busy_o);
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ($stable(vcode_o) && $stable(stages_o) && $stable(oor_o)));

  for (genvar p = 0; p < NPATH; p++) begin : g_chk
    a_r6_one_mechanism: assert property (@(posedge clk) disable iff (!rst_n)
      !((vcode_o[p*VCODE_W +: VCODE_W] != '0) &&
        (stages_o[p*STAGE_W +: STAGE_W] != '0)));

    a_r8_oor_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      oor_o[p] |-> (stages_o[p*STAGE_W +: STAGE_W] == STAGE_W'(NTAP - 1)));

    a_r9_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel_o[p*NTAP +: NTAP]) == 1);
  end
endmodule

bind tsc_ctrl tsc_ctrl_chk #(
  .NPATH(NPATH), .VCODE_W(VCODE_W), .STAGE_W(STAGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vcode_o   (vcode_o),
  .stages_o  (stages_o),
  .tap_sel_o (tap_sel_o),
  .oor_o     (oor_o),
  .done_o    (done_o),
  .busy_o    (busy_o)
);

// File: tb/sim_tsc_ctrl.sv
module sim_tsc_ctrl;
  localparam int NP  = 3;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  thresh_i;
  logic [2:0]  sched_last_i;
  logic        sched_we_i;
  logic [2:0]  sched_addr_i;
  logic [6:0]  sched_temp_i;
  logic [15:0] sched_dwell_i;
  logic        map_we_i;
  logic [2:0]  map_bin_i;
  logic [1:0]  map_path_i;
  logic [7:0]  map_delay_i;
  logic [11:0] vcode_o;
  logic [8:0]  stages_o;
  logic [23:0] tap_sel_o;
  logic [2:0]  oor_o;
  logic        done_o;
  logic        busy_o;

  tsc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .thresh_i(thresh_i),
    .sched_last_i(sched_last_i), .sched_we_i(sched_we_i),
    .sched_addr_i(sched_addr_i), .sched_temp_i(sched_temp_i),
    .sched_dwell_i(sched_dwell_i), .map_we_i(map_we_i),
    .map_bin_i(map_bin_i), .map_path_i(map_path_i),
    .map_delay_i(map_delay_i), .vcode_o(vcode_o), .stages_o(stages_o),
    .tap_sel_o(tap_sel_o), .oor_o(oor_o), .done_o(done_o), .busy_o(busy_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [11:0] vc;
    logic [8:0]  st;
    logic [23:0] tap;
    logic [2:0]  oor;
    int          gap;
  } exp_t;

  exp_t q[$];
  exp_t last_item;
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  int   ref_cyc = 0;
  int   done_cnt = 0;
  bit   finished = 1'b0;
  int   mapv [8][NP];
  int   s_temp [8];
  int   s_dwell [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mapfn(int b, int p);
    case (b)
      0: return (p == 0) ? 30 : (p == 1) ? 50 : 45;
      1: return (p == 0) ? 51 : (p == 1) ? 58 : 59;
      2: return (p == 0) ? 66 : (p == 1) ? 67 : 162;
      3: return (p == 0) ? 163 : (p == 1) ? 255 : 50;
      default: return 40 + b * 20 + p * 7;
    endcase
  endfunction

  // expected settings from R5..R9
  function automatic exp_t predict(int bin, int thr, int gap);
    exp_t e;
    e.vc = '0; e.st = '0; e.tap = '0; e.oor = '0; e.gap = gap;
    for (int p = 0; p < NP; p++) begin
      int d  = mapv[bin][p];
      int ex = (d > thr) ? d - thr : 0;
      int vc = 0;
      int st = 0;
      int fl = 0;
      if (ex >= 1 && ex <= 8) vc = ex;
      else if (ex > 8) begin
        st = (ex + 15) / 16;
        if (st > 7) begin st = 7; fl = 1; end
      end
      e.vc[p*4 +: 4] = 4'(vc);
      e.st[p*3 +: 3] = 3'(st);
      e.tap[p*8 + st] = 1'b1;
      e.oor[p] = 1'(fl);
    end
    return e;
  endfunction

  task automatic wr_map(int b, int p, int d);
    @(negedge clk);
    map_we_i = 1'b1; map_bin_i = 3'(b); map_path_i = 2'(p); map_delay_i = 8'(d);
    @(negedge clk);
    map_we_i = 1'b0;
    mapv[b][p] = d;
  endtask

  task automatic wr_sched(int i, int t, int d);
    @(negedge clk);
    sched_we_i = 1'b1; sched_addr_i = 3'(i);
    sched_temp_i = 7'(t); sched_dwell_i = 16'(d);
    @(negedge clk);
    sched_we_i = 1'b0;
    s_temp[i] = t; s_dwell[i] = d;
  endtask

  // driver: pushes expected items, then starts the run
  task automatic run(int last, int thr, bit inject);
    int gap;
    for (int i = 0; i <= last; i++) begin
      gap = (i == 0) ? LAT + NP + 1
                     : ((s_dwell[i-1] > LAT + NP) ? s_dwell[i-1] : LAT + NP) + 2;
      q.push_back(predict(s_temp[i] >> 4, thr, gap));
    end
    @(negedge clk);
    thresh_i = 8'(thr); sched_last_i = 3'(last);
    done_cnt = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ref_cyc = cyc;
    if (inject) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk("R12 done count", 32'(done_cnt), 32'(last + 1));
    chk("R10 queue drained", 32'(q.size()), 32'd0);
  endtask

  // monitor: compares each evaluation pass with the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      exp_t e;
      done_cnt++;
      if (q.size() == 0) begin
        chk("R10 unexpected done", 32'd1, 32'd0);
      end else begin
        e = q.pop_front();
        chk("R3/R10 done spacing", 32'(cyc - ref_cyc), 32'(e.gap));
        chk("R4/R6 voltage codes", 32'(vcode_o), 32'(e.vc));
        chk("R7 stage counts", 32'(stages_o), 32'(e.st));
        chk("R9 tap selects", 32'(tap_sel_o), 32'(e.tap));
        chk("R8 out-of-range flags", 32'(oor_o), 32'(e.oor));
        last_item = e;
      end
      ref_cyc = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; thresh_i = 8'd50; sched_last_i = '0;
    sched_we_i = 1'b0; sched_addr_i = '0; sched_temp_i = '0; sched_dwell_i = '0;
    map_we_i = 1'b0; map_bin_i = '0; map_path_i = '0; map_delay_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset vcode", 32'(vcode_o), 32'd0);
    chk("R1 reset stages", 32'(stages_o), 32'd0);
    chk("R1 reset taps", 32'(tap_sel_o), 32'h010101);
    chk("R1 reset flags", {28'd0, oor_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release busy", 32'(busy_o), 32'd0);

    for (int b = 0; b < 8; b++)
      for (int p = 0; p < NP; p++) wr_map(b, p, mapfn(b, p));
    // dwell 0 and 1 make done and dwell expiry coincide
    wr_sched(0, 5, 0);
    wr_sched(1, 20, 20);
    wr_sched(2, 35, 3);
    wr_sched(3, 60, 8);
    wr_sched(4, 70, 0);
    wr_sched(5, 90, 30);
    wr_sched(6, 100, 1);
    wr_sched(7, 127, 0);
    run(7, 50, 1'b1);

    // R11: idle and outputs held
    repeat (15) @(negedge clk);
    chk("R11 idle busy", 32'(busy_o), 32'd0);
    chk("R11 held vcode", 32'(vcode_o), 32'(last_item.vc));
    chk("R11 held stages", 32'(stages_o), 32'(last_item.st));
    chk("R11 held flags", 32'(oor_o), 32'(last_item.oor));

    // R2: rewritten map and schedule entries
    wr_map(1, 0, 200);
    wr_sched(0, 20, 5);
    wr_sched(1, 0, 0);
    run(1, 50, 1'b0);

    // R5: high threshold returns every path to nominal
    wr_sched(0, 127, 12);
    run(0, 255, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule